// File: doc/BRIEF.md
# Pixel Array Offset-Cancelling Scan Sequencer

This block steps through a 32 by 32 array of chemical sensor pixels and runs a two-phase digital correlated double sampling scheme. It addresses one pixel at a time with a one-hot row select and a binary column select. It powers up only the addressed pixel's output buffer and holds that pixel for a programmable dwell time, so that an external gain loop can settle. It then issues a start pulse to an external 8-bit successive-approximation converter and waits for that converter's done signal.

A calibration pass runs first, with the floating-gate reset switch closed one row at a time. Each pixel's converted value is kept in an internal 1024 by 8 offset memory, and nothing is streamed during this pass. Each signal pass that follows runs with the reset released. In every signal pass the stored offset of the addressed pixel is presented to a subtraction DAC while that pixel is converted. Each result leaves on a valid/ready port together with its pixel address and a frame-start marker. A programmable settling delay is inserted whenever the reset switch changes state between passes.

Top module: `cds_scan_ctrl`

## Requirements
- R1: After reset, row selects, row resets, the buffer enable, the converter start, the output valid and the offset-ready flag are all low.
- R2: A calibration request, whether taken from `cal_start_i` or held pending, starts a calibration pass from IDLE with priority over signal frames. The pass converts all 1024 pixels exactly once and produces no output words. At its end `ofs_valid_o` goes high. `ofs_valid_o` goes low when a calibration pass starts.
- R3: During a calibration pass, `row_rst_o` equals `row_sel_o`, so only the addressed row is reset. During signal passes `row_rst_o` is all zero.
- R4: Pixel address = row*32 + col. The row is driven one-hot on `row_sel_o` (bit r for row r) and the column is driven binary on `col_sel_o`. Pixels are visited in row-major order: the column advances first, and the row advances when the column wraps from 31 to 0.
- R5: The first pixel of a pass keeps `pix_en_o` high for exactly `dwell_cycles_i` cycles before `adc_start_o`. A value of 0 counts as 1.
- R6: When a pass changes the reset switch state, `pix_en_o` first rises exactly `settle_cycles_i` cycles after the pass is launched. When the switch state does not change, no settling gap is inserted, so back-to-back signal frames are separated by a single idle cycle.
- R7: `adc_start_o` is a one-cycle pulse. The address does not move and no new start is issued until `adc_done_i` is seen, however long the converter takes.
- R8: During signal-pass conversions `dac_code_o` equals the result that the most recent calibration pass stored for the addressed pixel. During calibration conversions `dac_code_o` is 0.
- R9: Each signal-pass output word carries the converted value, the 10-bit pixel address, and `out_sof_o` = 1 only for address 0. Words leave in scan order.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the scan stalls and the word is held unchanged. No word is dropped.
- R11: A signal frame starts only when `run_i` is high and `ofs_valid_o` is set. Lowering `run_i` stops scanning at the next frame boundary, after the current frame completes.
- R12: A calibration request made during a signal frame is latched. The frame completes in full before the calibration pass begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_start_i | input | 1 | Request a calibration pass |
| run_i | input | 1 | Enable continuous signal frames |
| dwell_cycles_i | input | 16 | Per-pixel dwell before conversion |
| settle_cycles_i | input | 16 | Delay after a reset-switch change |
| row_sel_o | output | 32 | One-hot row select |
| row_rst_o | output | 32 | Per-row reset switch control |
| col_sel_o | output | 5 | Column multiplexer select |
| pix_en_o | output | 1 | Addressed pixel buffer enable |
| dac_code_o | output | 8 | Offset code to subtraction DAC |
| adc_start_o | output | 1 | Converter start pulse |
| adc_done_i | input | 1 | Converter done |
| adc_data_i | input | 8 | Converter result |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted |
| out_addr_o | output | 10 | Pixel address of the word |
| out_data_o | output | 8 | Converted value |
| out_sof_o | output | 1 | Word is first of frame |
| ofs_valid_o | output | 1 | Offset table is complete |

## Verification
The converter result is captured on the edge that sees `adc_done_i`. In a signal pass the word is presented one cycle later and stays up until the handshake edge. The bench therefore records each transfer at the falling edge where both valid and ready are high. `pix_en_o` rises on the first dwell cycle and `adc_start_o` follows exactly the dwell count later. The bench measures that distance at falling edges, and it measures the settling gap as the number of falling edges with the enable still low after a launch. A launch takes effect on the first rising edge after `cal_start_i` or `run_i` is driven. The DAC code comes from a registered memory read, so it is checked at the start pulse, when at least one dwell cycle has passed since the address moved.

// File: rtl/cds_scan_pkg.sv
package cds_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DWELL,
    ST_START,
    ST_WAIT,
    ST_OUT
  } scan_state_e;
endpackage

// File: rtl/cds_scan_addr_gen.sv
module cds_scan_addr_gen #(
  parameter int ROWS = 32,
  parameter int COLS = 32,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            inc_i,
  output logic [RW-1:0]   row_o,
  output logic [CW-1:0]   col_o,
  output logic            last_o,
  output logic [ROWS-1:0] row_oh_o
);
  logic col_wrap;
  logic row_wrap;

  assign col_wrap = (col_o == CW'(COLS-1));
  assign row_wrap = (row_o == RW'(ROWS-1));
  assign last_o   = col_wrap && row_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o <= '0;
      col_o <= '0;
    end else if (clr_i) begin
      row_o <= '0;
      col_o <= '0;
    end else if (inc_i) begin
      if (col_wrap) begin
        col_o <= '0;
        row_o <= row_wrap ? '0 : row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
    assign row_oh_o[r] = (row_o == RW'(r));
  end

  // R4
  col_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && col_wrap && !row_wrap) |=> (col_o == '0 && row_o == $past(row_o) + 1'b1));
endmodule

// File: rtl/cds_scan_timer.sv
module cds_scan_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // zero and one both give a one-cycle interval
  assign expired_o = (cnt_q <= W'(1));
endmodule

// File: rtl/cds_offset_mem.sv
module cds_offset_mem #(
  parameter int DEPTH = 1024,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cds_scan_ctrl.sv
module cds_scan_ctrl
  import cds_scan_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int COLS   = 32,
  parameter int CODE_W = 8,
  parameter int TMR_W  = 16
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cal_start_i,
  input  logic                                  run_i,
  input  logic [TMR_W-1:0]                      dwell_cycles_i,
  input  logic [TMR_W-1:0]                      settle_cycles_i,
  output logic [ROWS-1:0]                       row_sel_o,
  output logic [ROWS-1:0]                       row_rst_o,
  output logic [$clog2(COLS)-1:0]               col_sel_o,
  output logic                                  pix_en_o,
  output logic [CODE_W-1:0]                     dac_code_o,
  output logic                                  adc_start_o,
  input  logic                                  adc_done_i,
  input  logic [CODE_W-1:0]                     adc_data_i,
  output logic                                  out_valid_o,
  input  logic                                  out_ready_i,
  output logic [$clog2(ROWS)+$clog2(COLS)-1:0]  out_addr_o,
  output logic [CODE_W-1:0]                     out_data_o,
  output logic                                  out_sof_o,
  output logic                                  ofs_valid_o
);
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int AW   = RW + CW;
  localparam int NPIX = ROWS * COLS;

  scan_state_e state_q, state_d;
  logic ofs_phase_q, ofs_phase_d;
  logic sw_closed_q, sw_closed_d;
  logic cal_req_q, ofs_valid_q;
  logic [CODE_W-1:0] res_q, rd_code;

  logic [RW-1:0]   row_idx;
  logic [CW-1:0]   col_idx;
  logic [ROWS-1:0] row_oh;
  logic [AW-1:0]   pix_addr;
  logic addr_last, addr_clr, adv, mem_we;
  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic launch_ofs, launch_sig, sel_active;

  cds_scan_addr_gen #(.ROWS(ROWS), .COLS(COLS)) addr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (addr_clr),
    .inc_i    (adv),
    .row_o    (row_idx),
    .col_o    (col_idx),
    .last_o   (addr_last),
    .row_oh_o (row_oh)
  );

  cds_scan_timer #(.W(TMR_W)) tmr_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  cds_offset_mem #(.DEPTH(NPIX), .DW(CODE_W)) mem_i (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (pix_addr),
    .wdata_i (adc_data_i),
    .raddr_i (pix_addr),
    .rdata_o (rd_code)
  );

  assign pix_addr   = {row_idx, col_idx};
  assign launch_ofs = (state_q == ST_IDLE) && (cal_req_q || cal_start_i);
  assign launch_sig = (state_q == ST_IDLE) && !launch_ofs && run_i && ofs_valid_q;

  always_comb begin
    state_d     = state_q;
    ofs_phase_d = ofs_phase_q;
    sw_closed_d = sw_closed_q;
    tmr_load    = 1'b0;
    tmr_val     = dwell_cycles_i;
    addr_clr    = 1'b0;
    adv         = 1'b0;
    mem_we      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch_ofs || launch_sig) begin
          addr_clr    = 1'b1;
          ofs_phase_d = launch_ofs;
          sw_closed_d = launch_ofs;
          tmr_load    = 1'b1;
          if (sw_closed_q != launch_ofs) begin
            state_d = ST_SETTLE;
            tmr_val = settle_cycles_i;
          end else begin
            state_d = ST_DWELL;
          end
        end
      end
      ST_SETTLE: if (tmr_exp) begin
        state_d  = ST_DWELL;
        tmr_load = 1'b1;
      end
      ST_DWELL: if (tmr_exp) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT: if (adc_done_i) begin
        if (ofs_phase_q) begin
          mem_we = 1'b1;
          adv    = 1'b1;
        end else begin
          state_d = ST_OUT;
        end
      end
      ST_OUT: if (out_ready_i) adv = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (addr_last) begin
        state_d = ST_IDLE;
      end else begin
        state_d  = ST_DWELL;
        tmr_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ofs_phase_q <= 1'b0;
      sw_closed_q <= 1'b0;
      cal_req_q   <= 1'b0;
      ofs_valid_q <= 1'b0;
      res_q       <= '0;
    end else begin
      state_q     <= state_d;
      ofs_phase_q <= ofs_phase_d;
      sw_closed_q <= sw_closed_d;
      cal_req_q   <= (cal_req_q | cal_start_i) & ~launch_ofs;
      if (launch_ofs)                          ofs_valid_q <= 1'b0;
      else if (adv && addr_last && ofs_phase_q) ofs_valid_q <= 1'b1;
      if (state_q == ST_WAIT && adc_done_i)     res_q <= adc_data_i;
    end
  end

  assign sel_active  = (state_q == ST_DWELL) || (state_q == ST_START) ||
                       (state_q == ST_WAIT)  || (state_q == ST_OUT);
  assign row_sel_o   = sel_active ? row_oh : '0;
  assign row_rst_o   = (sel_active && sw_closed_q) ? row_oh : '0;
  assign col_sel_o   = col_idx;
  assign pix_en_o    = sel_active;
  assign dac_code_o  = ofs_phase_q ? '0 : rd_code;
  assign adc_start_o = (state_q == ST_START);
  assign out_valid_o = (state_q == ST_OUT);
  assign out_addr_o  = pix_addr;
  assign out_data_o  = res_q;
  assign out_sof_o   = (pix_addr == '0);
  assign ofs_valid_o = ofs_valid_q;

  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> !adc_start_o);
  // R7
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !adc_done_i) |=> $stable(out_addr_o));
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_addr_o)));
  // R11
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ofs_valid_o);
  // R3
  sig_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (row_rst_o == '0));
  // R4
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o) && ((row_rst_o & ~row_sel_o) == '0));
  // R8
  cal_dac_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_start_o && row_rst_o != '0) |-> (dac_code_o == '0));
endmodule

// File: tb/cds_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module cds_scan_ctrl_tb_top;
  localparam int NPIX = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic cal_start, run;
  logic [15:0] dwell, settle;
  logic [31:0] row_sel, row_rst;
  logic [4:0]  col_sel;
  logic pix_en, adc_start, adc_done, out_valid, out_sof, ofs_valid;
  logic out_ready = 1'b1;
  logic [7:0] dac_code, adc_data, out_data;
  logic [9:0] out_addr;

  always #2.5 clk = ~clk;

  cds_scan_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cal_start_i(cal_start), .run_i(run),
    .dwell_cycles_i(dwell), .settle_cycles_i(settle),
    .row_sel_o(row_sel), .row_rst_o(row_rst), .col_sel_o(col_sel), .pix_en_o(pix_en),
    .dac_code_o(dac_code), .adc_start_o(adc_start), .adc_done_i(adc_done), .adc_data_i(adc_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_addr_o(out_addr),
    .out_data_o(out_data), .out_sof_o(out_sof), .ofs_valid_o(ofs_valid)
  );

  int checks = 0, errors = 0, cyc = 0;
  int adc_lat = 2;
  bit ready_mode = 0;
  logic [7:0] tb_ofs [NPIX];
  logic [7:0] tb_sig [NPIX];
  int salt = 0;
  int mon_addr_err = 0, mon_dac_err = 0, mon_rst_err = 0, mon_stall_err = 0;
  int mon_hs_err = 0, mon_data_err = 0, mon_ofsout_err = 0;
  int n_start = 0, n_out = 0, out_seq = 0, dwell_meas = 0, last_gap = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cur_addr();
    for (int r = 0; r < 32; r++)
      if (row_sel[r]) return r * 32 + int'(col_sel);
    return -1;
  endfunction

  // ready driver and watchdog
  initial begin
    for (int k = 0; k < 16; k++) begin tb_ofs[k] = 0; tb_sig[k] = 0; end
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = ready_mode ? (cyc % 3 == 0) : 1'b1;
      if (cyc > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=%0d expected<190000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // converter model
  initial begin
    int a; bit o; logic [7:0] v;
    adc_done = 0; adc_data = 0;
    forever begin
      @(negedge clk);
      if (adc_start) begin
        a = cur_addr();
        o = (row_rst != 0);
        for (int i = 0; i < adc_lat; i++) begin
          @(negedge clk);
          if (adc_start || cur_addr() != a) mon_hs_err++;
        end
        v = o ? 8'((a * 7 + salt) & 255) : 8'((a * 13 + salt) & 255);
        salt++;
        if (a >= 0) begin
          if (o) tb_ofs[a] = v; else tb_sig[a] = v;
        end
        adc_data = v; adc_done = 1;
        @(negedge clk);
        adc_done = 0; adc_data = 0;
      end
    end
  end

  // port monitor
  initial begin
    bit prev_pix = 0, prev_stall = 0, first = 0, cur_ofs = 0;
    logic [7:0] prev_data; logic [9:0] prev_addr;
    int seq = 0, pcnt = 0, gap = 0, a;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pix_en && !prev_pix) begin seq = 0; pcnt = 0; first = 1; last_gap = gap; end
        if (pix_en) begin pcnt++; gap = 0; end else gap++;
        if (adc_start) begin
          a = cur_addr();
          n_start++;
          if (first) begin dwell_meas = pcnt - 1; first = 0; end
          if ($countones(row_sel) != 1 || a != seq) mon_addr_err++;
          seq++;
          cur_ofs = (row_rst != 0);
          if (cur_ofs) begin
            if (row_rst != row_sel) mon_rst_err++;
            if (dac_code != 0) mon_dac_err++;
          end else begin
            if (row_rst != 0) mon_rst_err++;
            if (a >= 0 && dac_code != tb_ofs[a]) mon_dac_err++;
          end
        end
        if (out_valid && cur_ofs) mon_ofsout_err++;
        if (prev_stall && !(out_valid && out_data == prev_data && out_addr == prev_addr)) mon_stall_err++;
        if (out_valid && out_ready) begin
          n_out++;
          if (int'(out_addr) != out_seq) mon_data_err++;
          if (out_data != tb_sig[out_addr]) mon_data_err++;
          if (out_sof != (out_addr == 0)) mon_data_err++;
          out_seq = (out_seq + 1) % NPIX;
        end
        prev_stall = out_valid && !out_ready;
        prev_data = out_data; prev_addr = out_addr;
        prev_pix = pix_en;
      end
    end
  end

  task automatic launch_cal(output int g);
    cal_start = 1; g = 0;
    @(negedge clk);
    cal_start = 0;
    while (!pix_en) begin g++; @(negedge clk); end
  endtask

  task automatic launch_run(output int g);
    run = 1; g = 0;
    @(negedge clk);
    while (!pix_en) begin g++; @(negedge clk); end
  endtask

  task automatic t_reset;
    check(row_sel == 0 && row_rst == 0, "R1 selects", int'(row_sel | row_rst), 0);
    check(!pix_en && !adc_start, "R1 enable/start", int'(pix_en) + int'(adc_start), 0);
    check(!out_valid && !ofs_valid, "R1 valid flags", int'(out_valid) + int'(ofs_valid), 0);
  endtask

  task automatic t_run_gate;
    bit seen = 0;
    run = 1;
    repeat (100) begin @(negedge clk); if (pix_en || out_valid) seen = 1; end
    run = 0;
    check(!seen, "R11 no frame without offsets", int'(seen), 0);
  endtask

  task automatic t_offset_pass;
    int g, s0;
    dwell = 3; settle = 10; adc_lat = 2;
    s0 = n_start;
    launch_cal(g);
    check(g == 10, "R6 settle before calibration", g, 10);
    while (!ofs_valid) @(negedge clk);
    check(n_start - s0 == NPIX, "R2 pixels converted", n_start - s0, NPIX);
    check(n_out == 0, "R2 nothing streamed", n_out, 0);
    check(dwell_meas == 3, "R5 dwell", dwell_meas, 3);
    check(mon_addr_err == 0, "R4 scan order", mon_addr_err, 0);
    check(mon_rst_err == 0, "R3 row reset", mon_rst_err, 0);
    check(mon_hs_err == 0, "R7 handshake", mon_hs_err, 0);
    check(mon_ofsout_err == 0, "R2 no output in calibration", mon_ofsout_err, 0);
  endtask

  task automatic t_signal;
    int g, n0;
    n0 = n_out;
    launch_run(g);
    check(g == 10, "R6 settle before signal", g, 10);
    while (n_out < n0 + 2 * NPIX) @(negedge clk);
    run = 0;
    check(last_gap == 1, "R6 no settle between signal frames", last_gap, 1);
    repeat (100) @(negedge clk);
    check(n_out == n0 + 2 * NPIX, "R11 stops at frame boundary", n_out - n0, 2 * NPIX);
    check(!pix_en, "R11 idle after run low", int'(pix_en), 0);
    check(mon_data_err == 0, "R9 output words", mon_data_err, 0);
    check(mon_dac_err == 0, "R8 offset replay", mon_dac_err, 0);
    check(mon_rst_err == 0, "R3 no reset in signal", mon_rst_err, 0);
  endtask

  task automatic t_backpressure;
    int g, n0;
    ready_mode = 1;
    n0 = n_out;
    launch_run(g);
    check(g == 0, "R6 no settle when switch unchanged", g, 0);
    while (n_out < n0 + NPIX) @(negedge clk);
    run = 0;
    repeat (100) @(negedge clk);
    ready_mode = 0;
    check(mon_stall_err == 0, "R10 word held while stalled", mon_stall_err, 0);
    check(n_out - n0 == NPIX, "R10 no word dropped", n_out - n0, NPIX);
    check(mon_data_err == 0, "R10 data under stall", mon_data_err, 0);
  endtask

  task automatic t_cal_midframe;
    int g, n0, n1;
    n0 = n_out;
    launch_run(g);
    while (n_out < n0 + 300) @(negedge clk);
    cal_start = 1; @(negedge clk); cal_start = 0;
    while (ofs_valid) @(negedge clk);
    check(n_out % NPIX == 0, "R12 frame completes before calibration", n_out % NPIX, 0);
    check(row_rst == 0 || pix_en, "R12 calibration launched", int'(ofs_valid), 0);
    while (!ofs_valid) @(negedge clk);
    n1 = n_out;
    while (n_out < n1 + NPIX) @(negedge clk);
    run = 0;
    repeat (50) @(negedge clk);
    check(n_out - n1 == NPIX, "R12 signal resumes", n_out - n1, NPIX);
    check(mon_dac_err == 0, "R8 new offsets replayed", mon_dac_err, 0);
    check(mon_data_err == 0, "R9 words after recalibration", mon_data_err, 0);
  endtask

  task automatic t_dwell_zero;
    int g;
    dwell = 0; settle = 4; adc_lat = 1;
    launch_cal(g);
    check(g == 4, "R6 settle of 4", g, 4);
    while (!ofs_valid) @(negedge clk);
    check(dwell_meas == 1, "R5 zero dwell acts as one", dwell_meas, 1);
    dwell = 3;
  endtask

  task automatic t_slow_adc;
    int g, n0;
    adc_lat = 15;
    n0 = n_out;
    launch_run(g);
    check(g == 4, "R6 settle after recalibration", g, 4);
    while (n_out < n0 + NPIX) @(negedge clk);
    run = 0;
    repeat (50) @(negedge clk);
    check(mon_hs_err == 0, "R7 waits for slow done", mon_hs_err, 0);
    check(n_out - n0 == NPIX, "R7 one word per pixel", n_out - n0, NPIX);
    check(mon_data_err == 0, "R9 words with slow converter", mon_data_err, 0);
    check(mon_dac_err == 0, "R8 replay with slow converter", mon_dac_err, 0);
  endtask

  initial begin
    rst_n = 0; cal_start = 0; run = 0; dwell = 3; settle = 10;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_run_gate;
    t_offset_pass;
    t_signal;
    t_backpressure;
    t_cal_midframe;
    t_dwell_zero;
    t_slow_adc;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule